// File: doc/BRIEF.md
# USB Device Transaction Sequencer

This block is the control state machine that steers a full-speed USB device through one transaction at a time. A packet front end, kept outside the block, delivers received packets as bytes with a valid strobe and an end marker on the last byte. The sequencer decodes token packets addressed to the device. It keeps a pending flag, a data-toggle bit and a configured response (ACK, NAK or STALL) for each endpoint direction. From this state it decides whether to take in a data packet, start a data packet, send a handshake or wait for the host's handshake.

When a transaction completes with an acknowledgement, the endpoint's pending flag is raised and its toggle flips. Software sees the flags on the status outputs and clears a flag with a one-cycle clear strobe. While an endpoint's flag is raised, a configured ACK is answered as NAK. A SETUP token is always acknowledged and puts both directions of its endpoint back to a known toggle and response. If an expected packet does not arrive within a programmable number of idle cycles, the machine returns to waiting and changes no endpoint state.

The block emits only the PID byte of each outgoing packet. For a data packet the payload and CRC are appended by the transmit path, which is outside the block.

Top module: `usb_txn_seq`

## Requirements
- R1: After reset, seq_state is 0 (waiting), and every pending flag and every toggle is 0. Every response field reads NAK. Responses are coded ACK=0, NAK=1, STALL=2, and field k of ep_resp occupies bits [2k+1:2k].
- R2: In waiting state (code 0), a token is a 3-byte packet. Byte 0 is the PID byte; byte 1 holds the address in bits 6:0 and endpoint bit 0 in bit 7; byte 2 holds endpoint bits 3:1 in its bits 2:0. A token is acted on only if its address equals dev_addr and its endpoint number is below NEP. Any other token leaves the state at 0 and sends nothing.
- R3: A PID byte carries the PID in its low nibble and the PID's complement in its high nibble: OUT=1, IN=9, SOF=5, SETUP=13, DATA0=3, DATA1=11, ACK=2, NAK=10, STALL=14. Endpoint direction k has index 2*endpoint+dir, where dir is 1 for IN. An accepted IN token with effective response ACK sends a DATA PID byte and enters state 4 (awaiting handshake). Any other effective response sends that NAK or STALL byte and returns to state 0.
- R4: The effective response is NAK whenever the configured response is ACK and the endpoint's pending flag is set or being set in that cycle.
- R5: A data PID is sent as DATA0 when the endpoint's toggle is 0 and as DATA1 when it is 1.
- R6: In state 4, a one-byte ACK packet sets the endpoint's pending flag, flips its toggle and returns to state 0. Any other valid packet pulses hs_error for one cycle, returns to state 0 and changes neither flag.
- R7: An accepted OUT token captures the effective response of the OUT endpoint and enters state 1 (awaiting data). A DATA0 or DATA1 packet of at least 3 bytes then causes that response to be sent as a handshake. If the handshake is ACK, pending is set and the toggle flips.
- R8: An accepted SETUP token enters state 1 and is answered with ACK regardless of pending or configured response. It sets both directions of its endpoint to NAK, the OUT toggle to 0 and the IN toggle to 1.
- R9: A SOF token changes nothing in state 0 and in state 1.
- R10: A clr_valid strobe clears the pending flag at clr_idx, except when that same flag is being set in the same cycle, in which case the flag stays set.
- R11: In state 1 or 4, once the count of consecutive cycles with no packet in progress reaches tmo_limit, the machine returns to state 0. This leaves toggles and pending flags unchanged and sends nothing.
- R12: A cfg_we strobe writes cfg_resp into the response field at cfg_idx.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| dev_addr | input | 7 | Device address tokens must match |
| rx_valid | input | 1 | Received byte valid |
| rx_byte | input | 8 | Received byte |
| rx_end | input | 1 | Marks the last byte of a packet |
| cfg_we | input | 1 | Response write strobe |
| cfg_idx | input | IDX_W | Endpoint-direction index to write |
| cfg_resp | input | 2 | Response value to write |
| clr_valid | input | 1 | Pending clear strobe |
| clr_idx | input | IDX_W | Endpoint-direction index to clear |
| tmo_limit | input | TMO_W | Idle-cycle limit in receive states |
| tx_valid | output | 1 | Outgoing PID byte valid |
| tx_byte | output | 8 | Outgoing PID byte |
| ep_pending | output | 2*NEP | Pending flags |
| ep_toggle | output | 2*NEP | Data toggles |
| ep_resp | output | 4*NEP | Configured responses, 2 bits each |
| hs_error | output | 1 | Unexpected packet while awaiting handshake |
| seq_state | output | 3 | State: 0 wait, 1 recv data, 2 send hand, 3 send data, 4 recv hand |

## Verification
IN tokens are run against each configured response (NAK, STALL, ACK), which shows that the handshake choice follows the setting. A repeat IN is then sent while the pending flag is set, which shows the forced NAK apart from the configured ACK. Handshakes of ACK and then NAK from the host separate the completion path from the error path. A pending clear timed onto the completion cycle shows that the set wins. OUT transfers interleaved with SOF and a SETUP that overrides a NAK-forcing pending flag separate the ignore rule, the toggle reset and the forced ACK. Tokens with a foreign address, an out-of-range endpoint and missing follow-up packets show that the ignore and timeout paths leave every flag untouched.

// File: rtl/usb_txn_pkg.sv
package usb_txn_pkg;

  localparam logic [2:0] ST_WAIT      = 3'd0;
  localparam logic [2:0] ST_RECV_DATA = 3'd1;
  localparam logic [2:0] ST_SEND_HAND = 3'd2;
  localparam logic [2:0] ST_SEND_DATA = 3'd3;
  localparam logic [2:0] ST_RECV_HAND = 3'd4;

  localparam logic [1:0] RSP_ACK   = 2'd0;
  localparam logic [1:0] RSP_NAK   = 2'd1;
  localparam logic [1:0] RSP_STALL = 2'd2;

  localparam logic [3:0] PID_OUT   = 4'h1;
  localparam logic [3:0] PID_IN    = 4'h9;
  localparam logic [3:0] PID_SOF   = 4'h5;
  localparam logic [3:0] PID_SETUP = 4'hD;
  localparam logic [3:0] PID_DATA0 = 4'h3;
  localparam logic [3:0] PID_DATA1 = 4'hB;
  localparam logic [3:0] PID_ACK   = 4'h2;
  localparam logic [3:0] PID_NAK   = 4'hA;
  localparam logic [3:0] PID_STALL = 4'hE;

  // Full PID byte: check nibble above the PID
  function automatic logic [7:0] pid_byte(input logic [3:0] p);
    return {~p, p};
  endfunction

  function automatic logic pid_check(input logic [7:0] b);
    return b[7:4] == ~b[3:0];
  endfunction

  function automatic logic is_token_pid(input logic [3:0] p);
    return (p == PID_OUT) || (p == PID_IN) || (p == PID_SOF) || (p == PID_SETUP);
  endfunction

  function automatic logic is_data_pid(input logic [3:0] p);
    return (p == PID_DATA0) || (p == PID_DATA1);
  endfunction

  // ACK degrades to NAK while the endpoint still holds unserviced work
  function automatic logic [1:0] eff_resp(input logic [1:0] cfg, input logic busy);
    return ((cfg == RSP_ACK) && busy) ? RSP_NAK : cfg;
  endfunction

  function automatic logic [3:0] rsp_to_pid(input logic [1:0] r);
    case (r)
      RSP_ACK: return PID_ACK;
      RSP_NAK: return PID_NAK;
      default: return PID_STALL;
    endcase
  endfunction

endpackage

// File: rtl/usb_rx_parse.sv
module usb_rx_parse
  import usb_txn_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic [7:0]       rx_byte,
  input  logic             rx_end,
  output logic             in_pkt,
  output logic             pkt_done,
  output logic [3:0]       pkt_pid,
  output logic [CNT_W-1:0] pkt_len,
  output logic [6:0]       tok_addr,
  output logic [3:0]       tok_ep
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_inc;
  logic [CNT_W-1:0] len_q;
  logic [7:0]       byte0;
  logic [7:0]       byte1;
  logic [2:0]       byte2_ep;
  logic             done_q;

  assign cnt_inc = (cnt == CNT_MAX) ? cnt : cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      len_q    <= '0;
      byte0    <= 8'h00;
      byte1    <= 8'h00;
      byte2_ep <= 3'd0;
      done_q   <= 1'b0;
    end else begin
      done_q <= rx_valid && rx_end;
      if (rx_valid) begin
        if (cnt == CNT_W'(0)) byte0    <= rx_byte;
        if (cnt == CNT_W'(1)) byte1    <= rx_byte;
        if (cnt == CNT_W'(2)) byte2_ep <= rx_byte[2:0];
        if (rx_end) begin
          cnt   <= '0;
          len_q <= cnt_inc;
        end else begin
          cnt <= cnt_inc;
        end
      end
    end
  end

  assign in_pkt   = (cnt != '0);
  assign pkt_done = done_q && pid_check(byte0);
  assign pkt_pid  = byte0[3:0];
  assign pkt_len  = len_q;
  assign tok_addr = byte1[6:0];
  assign tok_ep   = {byte2_ep, byte1[7]};

endmodule

// File: rtl/usb_ep_state.sv
module usb_ep_state
  import usb_txn_pkg::*;
#(
  parameter int NEP   = 3,
  parameter int EP_W  = 2,
  parameter int IDX_W = 3,
  parameter int NIDX  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_fire,
  input  logic [IDX_W-1:0]  trig_idx,
  input  logic              clr_valid,
  input  logic [IDX_W-1:0]  clr_idx,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [1:0]        cfg_resp,
  input  logic              setup_fire,
  input  logic [EP_W-1:0]   setup_ep,
  output logic [NIDX-1:0]   pending,
  output logic [NIDX-1:0]   toggle,
  output logic [2*NIDX-1:0] resp
);

  for (genvar i = 0; i < NIDX; i++) begin : g_slot
    localparam bit IS_IN = (i % 2) == 1;
    logic       pend_q;
    logic       tog_q;
    logic [1:0] rsp_q;
    logic       hit_trig;
    logic       hit_clr;
    logic       hit_cfg;
    logic       hit_setup;

    assign hit_trig  = trig_fire && (trig_idx == IDX_W'(i));
    assign hit_clr   = clr_valid && (clr_idx == IDX_W'(i));
    assign hit_cfg   = cfg_we && (cfg_idx == IDX_W'(i));
    assign hit_setup = setup_fire && (setup_ep == EP_W'(i / 2));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q <= 1'b0;
        tog_q  <= 1'b0;
        rsp_q  <= RSP_NAK;
      end else begin
        // completion wins over a software clear in the same cycle
        if (hit_trig)     pend_q <= 1'b1;
        else if (hit_clr) pend_q <= 1'b0;

        if (hit_setup)     tog_q <= IS_IN;
        else if (hit_trig) tog_q <= ~tog_q;

        if (hit_setup)    rsp_q <= RSP_NAK;
        else if (hit_cfg) rsp_q <= cfg_resp;
      end
    end

    assign pending[i]       = pend_q;
    assign toggle[i]        = tog_q;
    assign resp[2*i +: 2]   = rsp_q;
  end

endmodule

// File: rtl/usb_tx_pid.sv
module usb_tx_pid
  import usb_txn_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       send_hand,
  input  logic [1:0] hs_rsp,
  input  logic       send_data,
  input  logic       data_tog,
  output logic       tx_valid,
  output logic [7:0] tx_byte
);

  logic [7:0] byte_d;

  always_comb begin
    if (send_data)      byte_d = pid_byte(data_tog ? PID_DATA1 : PID_DATA0);
    else if (send_hand) byte_d = pid_byte(rsp_to_pid(hs_rsp));
    else                byte_d = 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_byte  <= 8'h00;
    end else begin
      tx_valid <= send_hand || send_data;
      tx_byte  <= byte_d;
    end
  end

endmodule

// File: rtl/usb_txn_seq.sv
module usb_txn_seq
  import usb_txn_pkg::*;
#(
  parameter int NEP   = 3,
  parameter int TMO_W = 16,
  localparam int EP_W  = (NEP > 1) ? $clog2(NEP) : 1,
  localparam int IDX_W = EP_W + 1,
  localparam int NIDX  = 2 * NEP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [6:0]        dev_addr,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  input  logic              rx_end,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [1:0]        cfg_resp,
  input  logic              clr_valid,
  input  logic [IDX_W-1:0]  clr_idx,
  input  logic [TMO_W-1:0]  tmo_limit,
  output logic              tx_valid,
  output logic [7:0]        tx_byte,
  output logic [NIDX-1:0]   ep_pending,
  output logic [NIDX-1:0]   ep_toggle,
  output logic [2*NIDX-1:0] ep_resp,
  output logic              hs_error,
  output logic [2:0]        seq_state
);

  localparam int CNT_W = 3;
  localparam logic [TMO_W-1:0] TMR_MAX = {TMO_W{1'b1}};

  // parser outputs
  logic             in_pkt;
  logic             pkt_done;
  logic [3:0]       pkt_pid;
  logic [CNT_W-1:0] pkt_len;
  logic [6:0]       tok_addr;
  logic [3:0]       tok_ep;

  // named internal events
  logic             tok_ok;
  logic             data_ok;
  logic             hand_ack;
  logic             trig_fire;
  logic [IDX_W-1:0] trig_idx;
  logic             setup_fire;
  logic             tmo_fire;
  logic             recv_st;

  logic [2:0]       state_q, nxt;
  logic [IDX_W-1:0] cur_idx, cap_idx;
  logic [1:0]       cur_hs, cap_hs;
  logic             cap;
  logic             err_d;
  logic [TMO_W-1:0] tmr;

  logic [EP_W-1:0]  ep_sel;
  logic [IDX_W-1:0] idx_out, idx_in;
  logic [1:0]       eff_out, eff_in;

  usb_rx_parse #(.CNT_W(CNT_W)) u_parse (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_valid (rx_valid),
    .rx_byte  (rx_byte),
    .rx_end   (rx_end),
    .in_pkt   (in_pkt),
    .pkt_done (pkt_done),
    .pkt_pid  (pkt_pid),
    .pkt_len  (pkt_len),
    .tok_addr (tok_addr),
    .tok_ep   (tok_ep)
  );

  assign ep_sel  = tok_ep[EP_W-1:0];
  assign idx_out = {ep_sel, 1'b0};
  assign idx_in  = {ep_sel, 1'b1};

  assign tok_ok   = pkt_done && (pkt_len == CNT_W'(3)) && is_token_pid(pkt_pid)
                    && (tok_addr == dev_addr) && (int'(tok_ep) < NEP);
  assign data_ok  = pkt_done && is_data_pid(pkt_pid) && (pkt_len >= CNT_W'(3));
  assign hand_ack = pkt_done && (pkt_len == CNT_W'(1)) && (pkt_pid == PID_ACK);
  assign recv_st  = (state_q == ST_RECV_DATA) || (state_q == ST_RECV_HAND);

  // completion events raise pending and flip the toggle
  assign trig_fire = ((state_q == ST_SEND_HAND) && (cur_hs == RSP_ACK))
                     || ((state_q == ST_RECV_HAND) && hand_ack);
  assign trig_idx  = cur_idx;

  assign eff_out = eff_resp(ep_resp[{idx_out, 1'b0} +: 2],
                            ep_pending[idx_out] || (trig_fire && (trig_idx == idx_out)));
  assign eff_in  = eff_resp(ep_resp[{idx_in, 1'b0} +: 2],
                            ep_pending[idx_in] || (trig_fire && (trig_idx == idx_in)));

  assign tmo_fire = recv_st && !in_pkt && !rx_valid && !pkt_done && (tmr >= tmo_limit);

  always_comb begin
    nxt        = state_q;
    cap        = 1'b0;
    cap_idx    = cur_idx;
    cap_hs     = cur_hs;
    setup_fire = 1'b0;
    err_d      = 1'b0;
    case (state_q)
      ST_WAIT: begin
        if (tok_ok) begin
          case (pkt_pid)
            PID_SETUP: begin
              cap        = 1'b1;
              cap_idx    = idx_out;
              cap_hs     = RSP_ACK;
              setup_fire = 1'b1;
              nxt        = ST_RECV_DATA;
            end
            PID_OUT: begin
              cap     = 1'b1;
              cap_idx = idx_out;
              cap_hs  = eff_out;
              nxt     = ST_RECV_DATA;
            end
            PID_IN: begin
              cap     = 1'b1;
              cap_idx = idx_in;
              cap_hs  = eff_in;
              nxt     = (eff_in == RSP_ACK) ? ST_SEND_DATA : ST_SEND_HAND;
            end
            default: nxt = ST_WAIT; // SOF
          endcase
        end
      end
      ST_RECV_DATA: begin
        if (data_ok)       nxt = ST_SEND_HAND;
        else if (tmo_fire) nxt = ST_WAIT;
      end
      ST_SEND_HAND: nxt = ST_WAIT;
      ST_SEND_DATA: nxt = ST_RECV_HAND;
      ST_RECV_HAND: begin
        if (pkt_done) begin
          nxt   = ST_WAIT;
          err_d = !hand_ack;
        end else if (tmo_fire) begin
          nxt = ST_WAIT;
        end
      end
      default: nxt = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_WAIT;
      cur_idx  <= '0;
      cur_hs   <= RSP_NAK;
      hs_error <= 1'b0;
      tmr      <= '0;
    end else begin
      state_q  <= nxt;
      hs_error <= err_d;
      if (cap) begin
        cur_idx <= cap_idx;
        cur_hs  <= cap_hs;
      end
      if ((nxt != state_q) || !recv_st || in_pkt || rx_valid) tmr <= '0;
      else if (tmr != TMR_MAX)                                 tmr <= tmr + 1'b1;
    end
  end

  usb_ep_state #(.NEP(NEP), .EP_W(EP_W), .IDX_W(IDX_W), .NIDX(NIDX)) u_eps (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig_fire  (trig_fire),
    .trig_idx   (trig_idx),
    .clr_valid  (clr_valid),
    .clr_idx    (clr_idx),
    .cfg_we     (cfg_we),
    .cfg_idx    (cfg_idx),
    .cfg_resp   (cfg_resp),
    .setup_fire (setup_fire),
    .setup_ep   (ep_sel),
    .pending    (ep_pending),
    .toggle     (ep_toggle),
    .resp       (ep_resp)
  );

  usb_tx_pid u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .send_hand (state_q == ST_SEND_HAND),
    .hs_rsp    (cur_hs),
    .send_data (state_q == ST_SEND_DATA),
    .data_tog  (ep_toggle[cur_idx]),
    .tx_valid  (tx_valid),
    .tx_byte   (tx_byte)
  );

  assign seq_state = state_q;

endmodule

// File: rtl/usb_txn_seq_chk.sv
module usb_txn_seq_chk #(
  parameter int NIDX  = 6,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       seq_state,
  input logic             tx_valid,
  input logic             trig_fire,
  input logic [IDX_W-1:0] trig_idx,
  input logic             clr_valid,
  input logic [IDX_W-1:0] clr_idx,
  input logic             tmo_fire,
  input logic [NIDX-1:0]  ep_pending,
  input logic [NIDX-1:0]  ep_toggle
);

  // R1: state code stays within the five defined states
  a_r1_legal_state: assert property (@(posedge clk) disable iff (!rst_n)
    seq_state <= 3'd4);

  // R3: a PID byte appears only after a send state
  a_r3_tx_from_send: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> ($past(seq_state) == 3'd2 || $past(seq_state) == 3'd3));

  // R6: completion raises the endpoint's pending flag
  a_r6_done_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
    trig_fire |=> ep_pending[$past(trig_idx)]);

  // R6: completion flips the endpoint's toggle
  a_r6_done_flips_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    trig_fire |=> (ep_toggle[$past(trig_idx)] == ~$past(ep_toggle[trig_idx])));

  // R10: a clear colliding with a set leaves the flag set
  a_r10_clear_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_fire && clr_valid && (clr_idx == trig_idx)) |=> ep_pending[$past(clr_idx)]);

  // R11: a timeout goes home and leaves toggles alone
  a_r11_timeout_home: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_fire |=> (seq_state == 3'd0) && $stable(ep_toggle));

  // R11: a timeout without a software clear leaves pending alone
  a_r11_timeout_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_fire && !clr_valid) |=> $stable(ep_pending));

endmodule

bind usb_txn_seq usb_txn_seq_chk #(.NIDX(NIDX), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .seq_state  (seq_state),
  .tx_valid   (tx_valid),
  .trig_fire  (trig_fire),
  .trig_idx   (trig_idx),
  .clr_valid  (clr_valid),
  .clr_idx    (clr_idx),
  .tmo_fire   (tmo_fire),
  .ep_pending (ep_pending),
  .ep_toggle  (ep_toggle)
);

// File: tb/usb_txn_seq_bench.sv
module usb_txn_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  dev_addr = 7'h2A;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = 8'h00;
  logic        rx_end = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = 3'd0;
  logic [1:0]  cfg_resp = 2'd0;
  logic        clr_valid = 1'b0;
  logic [2:0]  clr_idx = 3'd0;
  logic [15:0] tmo_limit = 16'd30;
  logic        tx_valid;
  logic [7:0]  tx_byte;
  logic [5:0]  ep_pending;
  logic [5:0]  ep_toggle;
  logic [11:0] ep_resp;
  logic        hs_error;
  logic [2:0]  seq_state;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];

  always #5 clk = ~clk;

  usb_txn_seq u_usb_txn_seq (
    .clk(clk), .rst_n(rst_n), .dev_addr(dev_addr),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_end(rx_end),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_resp(cfg_resp),
    .clr_valid(clr_valid), .clr_idx(clr_idx), .tmo_limit(tmo_limit),
    .tx_valid(tx_valid), .tx_byte(tx_byte),
    .ep_pending(ep_pending), .ep_toggle(ep_toggle), .ep_resp(ep_resp),
    .hs_error(hs_error), .seq_state(seq_state)
  );

  function automatic logic [7:0] pb(input logic [3:0] p);
    pb = {p ^ 4'hF, p};
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] want);
    n_cmp++;
    if (got !== want) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, want);
    end
  endtask

  // monitor: every outgoing PID byte is popped and compared
  always @(negedge clk) begin
    if (rst_n && tx_valid) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R3 unexpected tx: actual %0h expected none", tx_byte);
      end else begin
        logic [7:0] w;
        w = exp_q.pop_front();
        if (tx_byte !== w) begin
          n_bad++;
          $display("FAIL R3/R5 tx byte: actual %0h expected %0h", tx_byte, w);
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bytes(input logic [7:0] b[$]);
    foreach (b[i]) begin
      @(negedge clk);
      rx_valid = 1'b1;
      rx_byte  = b[i];
      rx_end   = (i == b.size() - 1);
    end
    @(negedge clk);
    rx_valid = 1'b0;
    rx_end   = 1'b0;
  endtask

  task automatic token(input logic [3:0] pid, input logic [6:0] a, input logic [3:0] ep);
    send_bytes('{pb(pid), {ep[0], a}, {5'b0, ep[3:1]}});
  endtask

  task automatic set_resp(input logic [2:0] idx, input logic [1:0] r);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_resp = r;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic expect_tx(input logic [7:0] b);
    exp_q.push_back(b);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1
    chk("R1 state", 32'(seq_state), 0);
    chk("R1 pending", 32'(ep_pending), 0);
    chk("R1 toggle", 32'(ep_toggle), 0);
    chk("R1 resp", 32'(ep_resp), 32'h555);

    // R3: IN with NAK
    expect_tx(8'h5A);
    token(4'h9, 7'h2A, 4'd1);
    idle(8);
    chk("R3 back to wait", 32'(seq_state), 0);

    // R12 + R3: STALL
    set_resp(3'd3, 2'd2);
    chk("R12 resp written", 32'(ep_resp[7:6]), 2);
    expect_tx(8'h1E);
    token(4'h9, 7'h2A, 4'd1);
    idle(8);

    // R3 + R5 + R6 + R10: ACK, DATA0, host ACK with colliding clear
    set_resp(3'd3, 2'd0);
    expect_tx(8'hC3);
    token(4'h9, 7'h2A, 4'd1);
    idle(4);
    chk("R3 awaiting handshake", 32'(seq_state), 4);
    send_bytes('{8'hD2});
    clr_valid = 1'b1; clr_idx = 3'd3;
    @(negedge clk);
    clr_valid = 1'b0;
    idle(3);
    chk("R10 colliding clear ignored", 32'(ep_pending[3]), 1);
    chk("R6 toggle flipped", 32'(ep_toggle[3]), 1);
    chk("R6 back to wait", 32'(seq_state), 0);

    // R4: pending forces NAK
    expect_tx(8'h5A);
    token(4'h9, 7'h2A, 4'd1);
    idle(8);

    // R10 clear, R5 DATA1, R6 host NAK -> error
    @(negedge clk);
    clr_valid = 1'b1; clr_idx = 3'd3;
    @(negedge clk);
    clr_valid = 1'b0;
    idle(1);
    chk("R10 clear", 32'(ep_pending[3]), 0);
    expect_tx(8'h4B);
    token(4'h9, 7'h2A, 4'd1);
    idle(4);
    send_bytes('{8'h5A});
    @(negedge clk);
    chk("R6 hs_error pulse", 32'(hs_error), 1);
    idle(3);
    chk("R6 error pending kept", 32'(ep_pending[3]), 0);
    chk("R6 error toggle kept", 32'(ep_toggle[3]), 1);
    chk("R6 error to wait", 32'(seq_state), 0);

    // R7 + R9: OUT with SOF inside RECV_DATA
    set_resp(3'd4, 2'd0);
    token(4'h1, 7'h2A, 4'd2);
    idle(3);
    chk("R7 recv data", 32'(seq_state), 1);
    token(4'h5, 7'h2A, 4'd0);
    idle(2);
    chk("R9 SOF in recv data", 32'(seq_state), 1);
    expect_tx(8'hD2);
    send_bytes('{8'hC3, 8'h11, 8'h22, 8'h00, 8'h00});
    idle(6);
    chk("R7 pending", 32'(ep_pending[4]), 1);
    chk("R7 toggle", 32'(ep_toggle[4]), 1);
    chk("R7 wait", 32'(seq_state), 0);

    // R4 on OUT
    token(4'h1, 7'h2A, 4'd2);
    idle(3);
    expect_tx(8'h5A);
    send_bytes('{8'h4B, 8'h33, 8'h00, 8'h00});
    idle(6);
    chk("R4 NAK keeps toggle", 32'(ep_toggle[4]), 1);

    // R8: SETUP
    token(4'hD, 7'h2A, 4'd2);
    idle(3);
    chk("R8 out resp", 32'(ep_resp[9:8]), 1);
    chk("R8 in resp", 32'(ep_resp[11:10]), 1);
    chk("R8 out toggle", 32'(ep_toggle[4]), 0);
    chk("R8 in toggle", 32'(ep_toggle[5]), 1);
    expect_tx(8'hD2);
    send_bytes('{8'hC3, 8'h00, 8'h00});
    idle(6);
    chk("R8 acked toggle", 32'(ep_toggle[4]), 1);
    chk("R8 acked pending", 32'(ep_pending[4]), 1);

    // R2: foreign address, out-of-range endpoint
    token(4'h9, 7'h15, 4'd1);
    idle(6);
    chk("R2 foreign addr", 32'(seq_state), 0);
    token(4'h9, 7'h2A, 4'd5);
    idle(6);
    chk("R2 endpoint range", 32'(seq_state), 0);

    // R9: SOF in WAIT
    token(4'h5, 7'h2A, 4'd0);
    idle(4);
    chk("R9 SOF in wait", 32'(seq_state), 0);

    // R11: timeout in RECV_DATA
    token(4'h1, 7'h2A, 4'd0);
    idle(3);
    chk("R11 in recv data", 32'(seq_state), 1);
    idle(45);
    chk("R11 data timeout", 32'(seq_state), 0);
    chk("R11 pending kept", 32'(ep_pending), 32'h10);
    chk("R11 toggle kept", 32'(ep_toggle), 32'h38);

    // R11: timeout in RECV_HAND
    set_resp(3'd1, 2'd0);
    expect_tx(8'hC3);
    token(4'h9, 7'h2A, 4'd0);
    idle(45);
    chk("R11 hand timeout", 32'(seq_state), 0);
    chk("R11 hand pending", 32'(ep_pending[1]), 0);
    chk("R11 hand toggle", 32'(ep_toggle[1]), 0);

    idle(4);
    chk("R3 all expected bytes sent", 32'(exp_q.size()), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule